// File: doc/BRIEF.md
# Indexed Register Bank with Two-Step Access

This block is a host-side register bank that sits behind a narrow parallel bus with only three address lines. Six of the eight bus locations map straight onto storage registers. The remaining two locations are an index register and a data window. Together these two reach a second, larger set of 29 indirect registers. In total the bank covers 37 locations: 6 direct registers, the index register, the data window and 29 indirect registers.

To reach an indirect register, the host first writes the register's number into the index register. It then reads or writes the data window, which moves a word to or from the selected indirect register. The index is not changed by data-window traffic, so a host can hit the same indirect register again and again with one index write. Every storage register is exported as a flat vector so that neighbouring logic can use the settings. What each register means is decided outside this block.

Top module: `idx_regbank`

## Requirements
- R1: An active-low reset `rst_n` clears every direct register, every indirect register and the index register to zero.
- R2: A write (cs and wr high at a rising clock edge) to location k, 0 <= k <= 5, stores `wdata` into direct register k. That register appears on `dir_regs_o[k*8 +: 8]` after the edge, and no other direct register changes.
- R3: A write to location 6 loads the index register from `wdata`. A read of location 6 returns the index register.
- R4: While the index is below 29, a write to location 7 stores `wdata` into indirect register `index`, shown on `ind_regs_o[index*8 +: 8]`. A read of location 7 returns that register.
- R5: While the index is 29 or higher, a read of location 7 returns zero, and a write to location 7 changes no register.
- R6: Reads and writes of location 7 leave the index register unchanged.
- R7: When cs is low, or wr is low, a clock edge changes no register.
- R8: Reads are combinational. `rdata` shows the addressed register in the same cycle that cs and rd are both high, and is zero whenever cs or rd is low.
- R9: A read of location k, 0 <= k <= 5, returns direct register k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on its rising edge |
| rst_n | input | 1 | Active-low reset, clears all storage |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 3 | Bus location: 0-5 direct, 6 index, 7 data window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| dir_regs_o | output | 48 | Direct register contents, register k at bits k*8+7..k*8 |
| ind_regs_o | output | 232 | Indirect register contents, register j at bits j*8+7..j*8 |

## Verification
The hardest state to reach is an index that points past the last indirect register while the indirect registers already hold known, non-zero data. Only in that state can a dropped write or a leaking read be seen. The stimulus first fills indirect register 28, the last valid one, through the data window. It then loads index 29 and writes an all-ones word through the window. The bench confirms that the window reads zero and that the whole exported indirect vector still matches its model. Afterwards it moves the index back to a filled register and checks that the earlier contents come back intact.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
   localparam int DEF_ADDR_W  = 3;
   localparam int DEF_DATA_W  = 8;
   localparam int DEF_NUM_IND = 29;

   typedef enum logic [1:0] {
      LOC_DIRECT = 2'd0,
      LOC_INDEX  = 2'd1,
      LOC_WINDOW = 2'd2
   } loc_kind_e;
endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
   import regbank_pkg::*;
#(
   parameter int ADDR_W  = DEF_ADDR_W,
   parameter int DATA_W  = DEF_DATA_W,
   parameter int NUM_IND = DEF_NUM_IND,
   localparam int NUM_LOC = 1 << ADDR_W,
   localparam int NUM_DIR = NUM_LOC - 2
) (
   input  logic                cs,
   input  logic                wr,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   idx,
   output loc_kind_e           kind,
   output logic                idx_valid,
   output logic [NUM_DIR-1:0]  dir_we,
   output logic                idx_we,
   output logic [NUM_IND-1:0]  ind_we
);
   localparam logic [ADDR_W-1:0] IDX_LOC = ADDR_W'(NUM_LOC - 2);
   localparam logic [ADDR_W-1:0] WIN_LOC = ADDR_W'(NUM_LOC - 1);

   logic wr_go;
   assign wr_go = cs & wr;

   generate
      if (NUM_IND == (1 << DATA_W)) begin : g_full_range
         assign idx_valid = 1'b1;
      end else begin : g_part_range
         assign idx_valid = (idx < DATA_W'(NUM_IND));
      end
   endgenerate

   always_comb begin
      if (addr == IDX_LOC)      kind = LOC_INDEX;
      else if (addr == WIN_LOC) kind = LOC_WINDOW;
      else                      kind = LOC_DIRECT;
   end

   always_comb begin
      for (int i = 0; i < NUM_DIR; i++)
         dir_we[i] = wr_go && (kind == LOC_DIRECT) && (addr == ADDR_W'(i));
      idx_we = wr_go && (kind == LOC_INDEX);
      for (int j = 0; j < NUM_IND; j++)
         ind_we[j] = wr_go && (kind == LOC_WINDOW) && idx_valid && (idx == DATA_W'(j));
   end
endmodule

// File: rtl/regbank_store.sv
module regbank_store #(
   parameter int N = 6,
   parameter int W = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   we,
   input  logic [W-1:0]   wdata,
   output logic [N*W-1:0] q
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_cell
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q[i*W +: W] <= '0;
            else if (we[i]) q[i*W +: W] <= wdata;
         end

         // R7 / R5: a cell without its enable keeps its value
         assert_cell_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !we[i] |=> $stable(q[i*W +: W]));
         // R2 / R4: an enabled cell takes the write word
         assert_cell_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
            we[i] |=> (q[i*W +: W] == $past(wdata)));
      end
   endgenerate
endmodule

// File: rtl/regbank_rdmux.sv
module regbank_rdmux
   import regbank_pkg::*;
#(
   parameter int ADDR_W  = DEF_ADDR_W,
   parameter int DATA_W  = DEF_DATA_W,
   parameter int NUM_IND = DEF_NUM_IND,
   localparam int NUM_DIR = (1 << ADDR_W) - 2
) (
   input  logic                      cs,
   input  logic                      rd,
   input  logic [ADDR_W-1:0]         addr,
   input  loc_kind_e                 kind,
   input  logic                      idx_valid,
   input  logic [DATA_W-1:0]         idx,
   input  logic [NUM_DIR*DATA_W-1:0] dir_q,
   input  logic [NUM_IND*DATA_W-1:0] ind_q,
   output logic [DATA_W-1:0]         rdata
);
   logic [DATA_W-1:0] dir_sel, ind_sel;

   always_comb begin
      dir_sel = '0;
      for (int i = 0; i < NUM_DIR; i++)
         if (addr == ADDR_W'(i)) dir_sel = dir_q[i*DATA_W +: DATA_W];
      ind_sel = '0;
      for (int j = 0; j < NUM_IND; j++)
         if (idx_valid && idx == DATA_W'(j)) ind_sel = ind_q[j*DATA_W +: DATA_W];
   end

   always_comb begin
      if (!(cs && rd))             rdata = '0;
      else if (kind == LOC_INDEX)  rdata = idx;
      else if (kind == LOC_WINDOW) rdata = ind_sel;
      else                         rdata = dir_sel;
   end

   // R8: idle bus drives zero
   always_comb begin
      if (cs === 1'b0 || rd === 1'b0)
         assert_rd_idle_R8: assert (rdata == '0);
   end
   // R5: window reads zero when the index is out of range
   always_comb begin
      if (cs === 1'b1 && rd === 1'b1 && kind == LOC_WINDOW && idx_valid === 1'b0)
         assert_rd_oob_R5: assert (rdata == '0);
   end
endmodule

// File: rtl/idx_regbank.sv
module idx_regbank
   import regbank_pkg::*;
#(
   parameter int ADDR_W  = DEF_ADDR_W,
   parameter int DATA_W  = DEF_DATA_W,
   parameter int NUM_IND = DEF_NUM_IND,
   localparam int NUM_LOC = 1 << ADDR_W,
   localparam int NUM_DIR = NUM_LOC - 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cs,
   input  logic                      rd,
   input  logic                      wr,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [DATA_W-1:0]         wdata,
   output logic [DATA_W-1:0]         rdata,
   output logic [NUM_DIR*DATA_W-1:0] dir_regs_o,
   output logic [NUM_IND*DATA_W-1:0] ind_regs_o
);
   generate
      if (ADDR_W < 2 || ADDR_W > 8) begin : g_bad_addr
         $error("idx_regbank: ADDR_W must be 2..8");
      end
      if (NUM_IND < 1 || NUM_IND > (1 << DATA_W)) begin : g_bad_ind
         $error("idx_regbank: NUM_IND must fit the index width");
      end
      if (DATA_W < 1 || DATA_W > 32) begin : g_bad_data
         $error("idx_regbank: DATA_W must be 1..32");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] IDX_LOC = ADDR_W'(NUM_LOC - 2);
   localparam logic [ADDR_W-1:0] WIN_LOC = ADDR_W'(NUM_LOC - 1);

   logic [DATA_W-1:0]  idx_q;
   loc_kind_e          kind;
   logic               idx_valid;
   logic [NUM_DIR-1:0] dir_we;
   logic               idx_we;
   logic [NUM_IND-1:0] ind_we;

   regbank_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_IND(NUM_IND)) u_dec (
      .cs(cs), .wr(wr), .addr(addr), .idx(idx_q),
      .kind(kind), .idx_valid(idx_valid),
      .dir_we(dir_we), .idx_we(idx_we), .ind_we(ind_we)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx_q <= '0;
      else if (idx_we) idx_q <= wdata;
   end

   regbank_store #(.N(NUM_DIR), .W(DATA_W)) u_dir (
      .clk(clk), .rst_n(rst_n), .we(dir_we), .wdata(wdata), .q(dir_regs_o)
   );

   regbank_store #(.N(NUM_IND), .W(DATA_W)) u_ind (
      .clk(clk), .rst_n(rst_n), .we(ind_we), .wdata(wdata), .q(ind_regs_o)
   );

   regbank_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_IND(NUM_IND)) u_rd (
      .cs(cs), .rd(rd), .addr(addr), .kind(kind), .idx_valid(idx_valid),
      .idx(idx_q), .dir_q(dir_regs_o), .ind_q(ind_regs_o), .rdata(rdata)
   );

   // R2: at most one storage register is written per edge
   assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dir_we, idx_we, ind_we}));
   // R3: an index write loads the bus word
   assert_idx_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && wr && addr == IDX_LOC) |=> (idx_q == $past(wdata)));
   // R6: window traffic leaves the index alone
   assert_idx_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && (rd || wr) && addr == WIN_LOC) |=> $stable(idx_q));
   // R5: out-of-range window write leaves the indirect bank untouched
   assert_oob_nowr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && wr && addr == WIN_LOC && !idx_valid) |=> $stable(ind_regs_o));
   // R7: no strobe, no change anywhere
   assert_no_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(cs && wr) |=> ($stable(dir_regs_o) && $stable(ind_regs_o) && $stable(idx_q)));
endmodule

// File: tb/idx_regbank_tb.sv
module idx_regbank_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NDIR = 6;
   localparam int NIND = 29;
   localparam int NVEC = 19;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0, rd = 1'b0, wr = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [NDIR*8-1:0] dir_regs_o;
   logic [NIND*8-1:0] ind_regs_o;

   int checks = 0;
   int fails = 0;
   int cycles = 0;

   logic [7:0] m_dir [NDIR];
   logic [7:0] m_ind [NIND];
   logic [7:0] m_idx;

   always #(CLK_PERIOD/2) clk = ~clk;

   idx_regbank dut_i (
      .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr),
      .addr(addr), .wdata(wdata), .rdata(rdata),
      .dir_regs_o(dir_regs_o), .ind_regs_o(ind_regs_o)
   );

   // vector: {req[3:0], is_write, addr[2:0], wdata[7:0], expected[7:0]}
   localparam logic [23:0] VEC [NVEC] = '{
      {4'd2, 1'b1, 3'd0, 8'h11, 8'h00},  // R2 direct write 0
      {4'd2, 1'b1, 3'd5, 8'h5A, 8'h00},  // R2 direct write 5
      {4'd9, 1'b0, 3'd0, 8'h00, 8'h11},  // R9 read back 0
      {4'd9, 1'b0, 3'd5, 8'h00, 8'h5A},  // R9 read back 5
      {4'd3, 1'b1, 3'd6, 8'h03, 8'h00},  // R3 index = 3
      {4'd3, 1'b0, 3'd6, 8'h00, 8'h03},  // R3 index read
      {4'd4, 1'b1, 3'd7, 8'hC3, 8'h00},  // R4 window write
      {4'd4, 1'b0, 3'd7, 8'h00, 8'hC3},  // R4 window read
      {4'd6, 1'b0, 3'd6, 8'h00, 8'h03},  // R6 index kept
      {4'd3, 1'b1, 3'd6, 8'h1C, 8'h00},  // R3 index = 28 (last)
      {4'd4, 1'b1, 3'd7, 8'h7E, 8'h00},  // R4 last register
      {4'd4, 1'b0, 3'd7, 8'h00, 8'h7E},  // R4 last read
      {4'd5, 1'b1, 3'd6, 8'h1D, 8'h00},  // R5 index = 29
      {4'd5, 1'b1, 3'd7, 8'hFF, 8'h00},  // R5 ignored write
      {4'd5, 1'b0, 3'd7, 8'h00, 8'h00},  // R5 reads zero
      {4'd3, 1'b1, 3'd6, 8'h03, 8'h00},  // R3 back to 3
      {4'd6, 1'b0, 3'd7, 8'h00, 8'hC3},  // R6 contents intact
      {4'd3, 1'b1, 3'd6, 8'h00, 8'h00},  // R3 index = 0
      {4'd4, 1'b0, 3'd7, 8'h00, 8'h00}   // R4 unwritten reads zero
   };

   task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic check_ports(string tag);
      logic [NDIR*8-1:0] ed;
      logic [NIND*8-1:0] ei;
      for (int i = 0; i < NDIR; i++) ed[i*8 +: 8] = m_dir[i];
      for (int j = 0; j < NIND; j++) ei[j*8 +: 8] = m_ind[j];
      checks++;
      if (dir_regs_o !== ed || ind_regs_o !== ei) begin
         fails++;
         $display("FAIL %s: actual dir %h ind %h expected dir %h ind %h",
                  tag, dir_regs_o, ind_regs_o, ed, ei);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < NDIR; i++) m_dir[i] = '0;
      for (int j = 0; j < NIND; j++) m_ind[j] = '0;
      m_idx = '0;
   endtask

   task automatic bus_write(logic [2:0] a, logic [7:0] d);
      @(negedge clk);
      cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      cs = 1'b0; wr = 1'b0;
      if (a < 3'd6)       m_dir[a] = d;
      else if (a == 3'd6) m_idx = d;
      else if (m_idx < 8'(NIND)) m_ind[m_idx] = d;
   endtask

   task automatic bus_read(logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      cs = 1'b1; rd = 1'b1; addr = a;
      #1 d = rdata;
      cs = 1'b0; rd = 1'b0;
   endtask

   task automatic finish_run();
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         finish_run();
      end
   end

   initial begin
      logic [7:0] r;
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check_ports("R1 reset registers");
      bus_read(3'd6, r);
      check8("R1 reset index", r, 8'h00);

      // table walk
      for (int v = 0; v < NVEC; v++) begin
         string tag;
         tag = $sformatf("R%0d vector %0d", VEC[v][23:20], v);
         if (VEC[v][19]) bus_write(VEC[v][18:16], VEC[v][15:8]);
         else begin
            bus_read(VEC[v][18:16], r);
            check8(tag, r, VEC[v][7:0]);
         end
      end
      check_ports("R5 indirect bank after ignored write");

      // R8: same-cycle read, and zero when a strobe is missing
      @(negedge clk);
      cs = 1'b1; rd = 1'b1; addr = 3'd5;
      #1 check8("R8 combinational read", rdata, 8'h5A);
      rd = 1'b0;
      #1 check8("R8 rd low gives zero", rdata, 8'h00);
      cs = 1'b0; rd = 1'b1;
      #1 check8("R8 cs low gives zero", rdata, 8'h00);
      rd = 1'b0;

      // R7: strobes without select, select without strobe
      @(negedge clk);
      cs = 1'b0; wr = 1'b1; addr = 3'd1; wdata = 8'hA5;
      @(negedge clk);
      cs = 1'b1; wr = 1'b0; addr = 3'd6; wdata = 8'h1F;
      @(negedge clk);
      cs = 1'b0;
      check_ports("R7 no write without cs and wr");
      bus_read(3'd6, r);
      check8("R7 index untouched", r, 8'h00);

      // R2: only the addressed direct register moves
      bus_write(3'd3, 8'h3C);
      check_ports("R2 single direct write");

      // R6: window write then index unchanged, fill index 2
      bus_write(3'd6, 8'h02);
      bus_write(3'd7, 8'h99);
      bus_write(3'd7, 8'h9A);
      bus_read(3'd6, r);
      check8("R6 index after window writes", r, 8'h02);
      check_ports("R4 repeated window write");

      // R5: large index value
      bus_write(3'd6, 8'hFF);
      bus_write(3'd7, 8'h44);
      bus_read(3'd7, r);
      check8("R5 index FF reads zero", r, 8'h00);
      check_ports("R5 index FF write ignored");

      // R1: reset in the middle of operation
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      model_clear();
      check_ports("R1 mid-run reset");
      bus_read(3'd6, r);
      check8("R1 index cleared", r, 8'h00);
      bus_read(3'd0, r);
      check8("R1 direct cleared", r, 8'h00);

      finish_run();
   end
endmodule